// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

This block follows a linked list of 16-byte scatter-gather descriptors in memory. When it is started with the address of the first descriptor, it reads the descriptor as four 32-bit words over a simple memory read port. It then gives a data mover one transfer request with the buffer address, the byte count, the direction, an ordering hint and a 4-bit transfer mode. When the data mover acknowledges the request, the block either follows the descriptor's next pointer or, if the descriptor is marked final, ends the walk.

Every 32-bit field is little-endian. Word 0 holds the buffer address. Word 1 holds the length in units of 8 bytes. Word 2 holds a flags byte in bits 7:0 and a mode byte in bits 15:8, and its upper two bytes are reserved. Word 3 holds the address of the next descriptor. Descriptors sit on 8-byte boundaries.

A descriptor whose length is zero ends the walk with an error. A safety cap also ends any chain that would run past a parameterised number of descriptors. The block never has more than one memory read or one transfer request outstanding.

Top module: `sg_chain_walker`

## Requirements
- R1: A descriptor is fetched as four read requests at its base address plus 0, 4, 8 and 12, in that order. Each read request is a single-cycle pulse on `rd_req`, and the next one is not issued until `rd_valid` has returned the previous word.
- R2: `xfer_addr` equals word 0, and `xfer_bytes` equals word 1 multiplied by 8.
- R3: `xfer_write` is bit 5 of word 2 (host to device), and `xfer_ordered` is bit 4 of word 2. `xfer_mode` is bits 11:8 of word 2. Bits 15:12 and 31:16 of word 2 have no effect on any output.
- R4: Only one transfer request is outstanding at a time. `xfer_req` stays high with all of its fields stable until the cycle in which `xfer_ack` is sampled high. No memory read is issued while `xfer_req` is high.
- R5: After a non-final descriptor is acknowledged, the next fetch starts at its word 3 pointer. The low 3 bits of both the start address and every next pointer are cleared before use.
- R6: When bit 7 of word 2 marks a descriptor as final, its next pointer is never read. `done` pulses for one cycle in the cycle right after the acknowledge is sampled, and `busy` is low in that same cycle.
- R7: A descriptor whose length word is zero produces no transfer request. Instead, `err` pulses for one cycle with `err_code` = 1 and the walk ends.
- R8: A walk accepts at most `MAX_ENTRIES` transfers. If the descriptor at position `MAX_ENTRIES` is acknowledged and is not final, `err` pulses with `err_code` = 2, one cycle after that acknowledge, and no further read is issued. A chain of exactly `MAX_ENTRIES` descriptors that ends with a final one completes with `done`.
- R9: `start` is ignored while `busy` is high: the read address sequence and the transfers of the walk in progress are unchanged.
- R10: While reset is asserted and just after it is released, `busy`, `rd_req`, `xfer_req`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (accepted only when idle) |
| start_addr | input | 32 | Address of the first descriptor |
| busy | output | 1 | A walk is in progress |
| rd_req | output | 1 | Single-cycle memory read request |
| rd_addr | output | 32 | Word address of the read |
| rd_valid | input | 1 | Read data is returned this cycle |
| rd_data | input | 32 | Returned read word |
| xfer_req | output | 1 | Transfer request to the data mover |
| xfer_addr | output | 32 | Buffer address of the transfer |
| xfer_bytes | output | 35 | Transfer length in bytes |
| xfer_write | output | 1 | 1 = host to device |
| xfer_ordered | output | 1 | Ordering hint from the descriptor |
| xfer_mode | output | 4 | Transfer mode from the descriptor |
| xfer_ack | input | 1 | Data mover finished the transfer |
| done | output | 1 | One-cycle pulse: chain completed |
| err | output | 1 | One-cycle pulse: walk aborted |
| err_code | output | 2 | Reason for the abort, valid with `err` (1 zero length, 2 chain too long) |

## Verification
A wrong word index or a wrong base register shows up in the very next `rd_addr` pulse, or in the field values of the next transfer request. Either appears within a few cycles of the read that returned the bad data. A wrong walk state shows up at the next acknowledge. It can appear as an extra or a missing read, as `done` or `err` not arriving exactly one cycle later, or as a transfer request that appears while a read is pending. A miscounted cap appears only at the boundary, so chains of exactly `MAX_ENTRIES` descriptors are walked both with and without a final mark.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

  localparam int WORD_W         = 32;
  localparam int WORDS_PER_DESC = 4;
  localparam int DESC_W         = WORD_W * WORDS_PER_DESC;
  localparam int GRAIN_SHIFT    = 3;
  localparam int BYTES_W        = WORD_W + GRAIN_SHIFT;
  localparam int MODE_W         = 4;

  // word positions inside a descriptor
  localparam int W_BUF   = 0;
  localparam int W_LEN   = 1;
  localparam int W_CTL   = 2;
  localparam int W_NEXT  = 3;

  // bit positions inside the control word
  localparam int BIT_ORDER  = 4;
  localparam int BIT_TO_DEV = 5;
  localparam int BIT_FINAL  = 7;
  localparam int MODE_LSB   = 8;

  typedef enum logic [1:0] {
    FAULT_NONE     = 2'd0,
    FAULT_ZERO_LEN = 2'd1,
    FAULT_TOO_LONG = 2'd2
  } fault_e;

  typedef struct packed {
    logic [WORD_W-1:0] buf_addr;
    logic [WORD_W-1:0] units;
    logic              ordered;
    logic              to_dev;
    logic              last;
    logic [MODE_W-1:0] mode;
    logic [WORD_W-1:0] next_ptr;
  } desc_t;

endpackage

// File: rtl/sgw_fetch.sv
module sgw_fetch
  import sgw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [WORD_W-1:0] base,
  output logic              rd_req,
  output logic [WORD_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [WORD_W-1:0] rd_data,
  output logic              ready,
  output logic [DESC_W-1:0] words
);

  localparam int IDX_W = $clog2(WORDS_PER_DESC);

  typedef enum logic [1:0] {F_IDLE, F_REQ, F_WAIT} fstate_e;

  fstate_e           st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [WORD_W-1:0] base_q, base_d;
  logic              ready_q, ready_d;
  logic              cap_en;
  logic              unused_low;

  assign unused_low = ^base[GRAIN_SHIFT-1:0];

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    base_d  = base_q;
    ready_d = 1'b0;
    cap_en  = 1'b0;
    case (st_q)
      F_IDLE: begin
        if (launch) begin
          st_d   = F_REQ;
          idx_d  = '0;
          base_d = {base[WORD_W-1:GRAIN_SHIFT], {GRAIN_SHIFT{1'b0}}};
        end
      end
      F_REQ: st_d = F_WAIT;
      F_WAIT: begin
        if (rd_valid) begin
          cap_en = 1'b1;
          if (idx_q == IDX_W'(WORDS_PER_DESC - 1)) begin
            st_d    = F_IDLE;
            ready_d = 1'b1;
          end else begin
            idx_d = idx_q + IDX_W'(1);
            st_d  = F_REQ;
          end
        end
      end
      default: st_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= F_IDLE;
      idx_q   <= '0;
      base_q  <= '0;
      ready_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      base_q  <= base_d;
      ready_q <= ready_d;
    end
  end

  for (genvar g = 0; g < WORDS_PER_DESC; g++) begin : g_word
    logic [WORD_W-1:0] w_q;
    logic              w_en;
    assign w_en = cap_en && (idx_q == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    w_q <= '0;
      else if (w_en) w_q <= rd_data;
    end
    assign words[g*WORD_W +: WORD_W] = w_q;
  end

  assign rd_req  = (st_q == F_REQ);
  assign rd_addr = base_q + {{(WORD_W-IDX_W-2){1'b0}}, idx_q, 2'b00};
  assign ready   = ready_q;

endmodule

// File: rtl/sgw_decode.sv
module sgw_decode
  import sgw_pkg::*;
(
  input  logic [DESC_W-1:0] words,
  output desc_t             desc
);

  logic [WORD_W-1:0] ctl;
  logic              unused_rsvd;

  assign ctl = words[W_CTL*WORD_W +: WORD_W];

  assign desc.buf_addr = words[W_BUF*WORD_W  +: WORD_W];
  assign desc.units    = words[W_LEN*WORD_W  +: WORD_W];
  assign desc.next_ptr = words[W_NEXT*WORD_W +: WORD_W];
  assign desc.ordered  = ctl[BIT_ORDER];
  assign desc.to_dev   = ctl[BIT_TO_DEV];
  assign desc.last     = ctl[BIT_FINAL];
  assign desc.mode     = ctl[MODE_LSB +: MODE_W];

  assign unused_rsvd = ^{ctl[WORD_W-1:MODE_LSB+MODE_W], ctl[6], ctl[3:0]};

endmodule

// File: rtl/sgw_ctrl.sv
module sgw_ctrl
  import sgw_pkg::*;
#(
  parameter int MAX_ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] start_addr,
  input  logic              ready,
  input  logic [WORD_W-1:0] units,
  input  logic              last,
  input  logic [WORD_W-1:0] next_ptr,
  input  logic              xfer_ack,
  output logic              launch,
  output logic [WORD_W-1:0] launch_base,
  output logic              xfer_req,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [1:0]        err_code
);

  localparam int CNT_W = $clog2(MAX_ENTRIES + 1);

  typedef enum logic [1:0] {C_IDLE, C_FETCH, C_XFER} cstate_e;

  cstate_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             err_q, err_d;
  fault_e           code_q, code_d;
  logic             cap_hit;

  assign cap_hit = (cnt_q == CNT_W'(MAX_ENTRIES - 1));

  always_comb begin
    st_d        = st_q;
    cnt_d       = cnt_q;
    done_d      = 1'b0;
    err_d       = 1'b0;
    code_d      = code_q;
    launch      = 1'b0;
    launch_base = start_addr;
    case (st_q)
      C_IDLE: begin
        if (start) begin
          launch = 1'b1;
          cnt_d  = '0;
          code_d = FAULT_NONE;
          st_d   = C_FETCH;
        end
      end
      C_FETCH: begin
        if (ready) begin
          if (units == '0) begin
            err_d  = 1'b1;
            code_d = FAULT_ZERO_LEN;
            st_d   = C_IDLE;
          end else begin
            st_d = C_XFER;
          end
        end
      end
      C_XFER: begin
        if (xfer_ack) begin
          if (last) begin
            done_d = 1'b1;
            st_d   = C_IDLE;
          end else if (cap_hit) begin
            err_d  = 1'b1;
            code_d = FAULT_TOO_LONG;
            st_d   = C_IDLE;
          end else begin
            cnt_d       = cnt_q + CNT_W'(1);
            launch      = 1'b1;
            launch_base = next_ptr;
            st_d        = C_FETCH;
          end
        end
      end
      default: st_d = C_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= C_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      code_q <= FAULT_NONE;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      err_q  <= err_d;
      code_q <= code_d;
    end
  end

  assign xfer_req = (st_q == C_XFER);
  assign busy     = (st_q != C_IDLE);
  assign done     = done_q;
  assign err      = err_q;
  assign err_code = code_q;

endmodule

// File: rtl/sg_chain_walker.sv
module sg_chain_walker
  import sgw_pkg::*;
#(
  parameter int MAX_ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [WORD_W-1:0]  start_addr,
  output logic               busy,
  output logic               rd_req,
  output logic [WORD_W-1:0]  rd_addr,
  input  logic               rd_valid,
  input  logic [WORD_W-1:0]  rd_data,
  output logic               xfer_req,
  output logic [WORD_W-1:0]  xfer_addr,
  output logic [BYTES_W-1:0] xfer_bytes,
  output logic               xfer_write,
  output logic               xfer_ordered,
  output logic [MODE_W-1:0]  xfer_mode,
  input  logic               xfer_ack,
  output logic               done,
  output logic               err,
  output logic [1:0]         err_code
);

  logic              launch;
  logic [WORD_W-1:0] launch_base;
  logic              ready;
  logic [DESC_W-1:0] words;
  desc_t             desc;

  sgw_fetch u_fetch (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch),
    .base     (launch_base),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .ready    (ready),
    .words    (words)
  );

  sgw_decode u_decode (
    .words (words),
    .desc  (desc)
  );

  sgw_ctrl #(.MAX_ENTRIES(MAX_ENTRIES)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .start_addr  (start_addr),
    .ready       (ready),
    .units       (desc.units),
    .last        (desc.last),
    .next_ptr    (desc.next_ptr),
    .xfer_ack    (xfer_ack),
    .launch      (launch),
    .launch_base (launch_base),
    .xfer_req    (xfer_req),
    .busy        (busy),
    .done        (done),
    .err         (err),
    .err_code    (err_code)
  );

  assign xfer_addr    = desc.buf_addr;
  assign xfer_bytes   = {desc.units, {GRAIN_SHIFT{1'b0}}};
  assign xfer_write   = desc.to_dev;
  assign xfer_ordered = desc.ordered;
  assign xfer_mode    = desc.mode;

endmodule

// File: rtl/sgw_checker.sv
module sgw_checker
  import sgw_pkg::*;
#(
  parameter int MAX_ENTRIES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               busy,
  input logic               rd_req,
  input logic [WORD_W-1:0]  rd_addr,
  input logic               rd_valid,
  input logic               xfer_req,
  input logic [WORD_W-1:0]  xfer_addr,
  input logic [BYTES_W-1:0] xfer_bytes,
  input logic               xfer_ack,
  input logic               done,
  input logic               err
);

  localparam int CNT_W = $clog2(MAX_ENTRIES + 2);

  logic [CNT_W-1:0] acks_q;
  logic             rd_open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acks_q    <= '0;
      rd_open_q <= 1'b0;
    end else begin
      if (start && !busy)
        acks_q <= '0;
      else if (xfer_req && xfer_ack && acks_q != CNT_W'(MAX_ENTRIES + 1))
        acks_q <= acks_q + CNT_W'(1);
      if (rd_req)
        rd_open_q <= 1'b1;
      else if (rd_valid)
        rd_open_q <= 1'b0;
    end
  end

  AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_open_q |-> !rd_req);                                              // R1
  AST_BYTES_GRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> (xfer_bytes[GRAIN_SHIFT-1:0] == '0));                   // R2
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_addr) && $stable(xfer_bytes))); // R4
  AST_NO_READ_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> !rd_req);                                               // R4
  AST_ALIGNED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_addr[1:0] == 2'b00));                                 // R5
  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(xfer_req && xfer_ack) && !busy));                    // R6
  AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));                                                     // R6
  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> (xfer_bytes != '0));                                    // R7
  AST_CAP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    acks_q <= CNT_W'(MAX_ENTRIES));                                      // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_req && !xfer_req));                                   // R10

endmodule

bind sg_chain_walker sgw_checker #(.MAX_ENTRIES(MAX_ENTRIES)) u_sgw_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .rd_req     (rd_req),
  .rd_addr    (rd_addr),
  .rd_valid   (rd_valid),
  .xfer_req   (xfer_req),
  .xfer_addr  (xfer_addr),
  .xfer_bytes (xfer_bytes),
  .xfer_ack   (xfer_ack),
  .done       (done),
  .err        (err)
);

// File: tb/test_sg_chain_walker.sv
module test_sg_chain_walker;
  import sgw_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int MAXE       = 8;

  typedef struct packed {
    logic [31:0] a;
    logic [34:0] b;
    logic        w;
    logic        o;
    logic [3:0]  m;
  } xfer_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_addr = '0;
  logic        busy, rd_req, xfer_req, xfer_write, xfer_ordered, done, err;
  logic [31:0] rd_addr, xfer_addr;
  logic [34:0] xfer_bytes;
  logic [3:0]  xfer_mode;
  logic [1:0]  err_code;
  logic        rd_valid = 1'b0;
  logic [31:0] rd_data = '0;
  logic        xfer_ack = 1'b0;

  logic [31:0] mem [0:1023];
  logic [31:0] exp_rd[$];
  xfer_t       exp_x[$];
  int          exp_term[$];
  int          n_chk = 0;
  int          n_fail = 0;
  int          rd_lat = 0;
  int          ack_lat = 0;

  bit          pend = 0;
  int          dly = 0;
  logic [31:0] paddr = '0;
  bit          seen = 0;
  int          waitc = 0;
  xfer_t       cur;

  always #(CLK_PERIOD/2) clk = ~clk;

  sg_chain_walker #(.MAX_ENTRIES(MAXE)) i_sg_chain_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .busy(busy),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .xfer_req(xfer_req), .xfer_addr(xfer_addr), .xfer_bytes(xfer_bytes),
    .xfer_write(xfer_write), .xfer_ordered(xfer_ordered), .xfer_mode(xfer_mode),
    .xfer_ack(xfer_ack), .done(done), .err(err), .err_code(err_code)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // driver: writes one descriptor and queues what the walk should produce
  task automatic put_entry(input logic [31:0] at, input logic [31:0] bufa,
                           input logic [31:0] units, input logic [7:0] flags,
                           input logic [3:0] mode, input logic [31:0] nxt);
    logic [31:0] al;
    xfer_t       x;
    al = {at[31:3], 3'b000};
    mem[al[11:2]]          = bufa;
    mem[al[11:2] + 10'd1]  = units;
    mem[al[11:2] + 10'd2]  = {8'hA5, 8'h5A, 4'hF, mode, flags};
    mem[al[11:2] + 10'd3]  = nxt;
    for (int k = 0; k < 4; k++) exp_rd.push_back(al + 32'(4*k));
    if (units != 0) begin
      x.a = bufa; x.b = {units, 3'b000}; x.w = flags[5]; x.o = flags[4]; x.m = mode;
      exp_x.push_back(x);
    end
  endtask

  task automatic run_walk(input logic [31:0] sa, input int term, input int intrude);
    exp_term.push_back(term);
    @(negedge clk); start = 1'b1; start_addr = sa;
    @(negedge clk); start = 1'b0;
    if (intrude > 0) begin
      repeat (intrude) @(negedge clk);
      check(busy == 1'b1, "R9", "busy before second start", busy, 1);
      start = 1'b1; start_addr = 32'h0000_0400;
      @(negedge clk); start = 1'b0;
    end
    while (exp_term.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(exp_rd.size() == 0, "R1", "reads left unissued", exp_rd.size(), 0);
    check(exp_x.size() == 0, "R2", "transfers left unissued", exp_x.size(), 0);
    check(busy == 1'b0, "R6", "busy after walk", busy, 0);
  endtask

  // monitor and memory / data-mover models, all acting on the falling edge
  always @(negedge clk) begin
    bit ack_prev;
    ack_prev = xfer_ack;
    rd_valid = 1'b0;
    if (pend) begin
      if (dly == 0) begin
        rd_valid = 1'b1; rd_data = mem[paddr[11:2]]; pend = 0;
      end else dly--;
    end
    if (rd_req) begin
      if (exp_rd.size() == 0) check(0, "R1", "unexpected read", rd_addr, 0);
      else begin
        logic [31:0] e;
        e = exp_rd.pop_front();
        check(rd_addr == e, "R5", "read address", rd_addr, e);
      end
      check(!xfer_req, "R4", "read during transfer", xfer_req, 0);
      pend = 1; paddr = rd_addr; dly = rd_lat;
    end
    if (xfer_ack) begin
      xfer_ack = 1'b0; seen = 0;
    end else if (xfer_req) begin
      if (!seen) begin
        seen = 1; waitc = 0;
        cur = {xfer_addr, xfer_bytes, xfer_write, xfer_ordered, xfer_mode};
        if (exp_x.size() == 0) check(0, "R7", "unexpected transfer", cur, 0);
        else begin
          xfer_t e;
          e = exp_x.pop_front();
          check(cur.a == e.a, "R2", "transfer address", cur.a, e.a);
          check(cur.b == e.b, "R2", "transfer bytes", cur.b, e.b);
          check({cur.w, cur.o} == {e.w, e.o}, "R3", "direction/order", {cur.w, cur.o}, {e.w, e.o});
          check(cur.m == e.m, "R3", "mode", cur.m, e.m);
        end
      end
      if (waitc >= ack_lat) begin
        check({xfer_addr, xfer_bytes, xfer_write, xfer_ordered, xfer_mode} == cur,
              "R4", "fields held until ack", {xfer_addr, xfer_bytes}, {cur.a, cur.b});
        xfer_ack = 1'b1;
      end else waitc++;
    end
    if (done || err) begin
      if (exp_term.size() == 0) check(0, "R6", "unexpected end", {done, err}, 0);
      else begin
        int t;
        t = exp_term.pop_front();
        if (t == 0) begin
          check(done && !err, "R6", "completion", {done, err}, 2'b10);
          check(ack_prev, "R6", "done one cycle after ack", ack_prev, 1);
        end else begin
          check(err && !done && err_code == 2'(t), (t == 1) ? "R7" : "R8",
                "abort code", {err, err_code}, {1'b1, 2'(t)});
          if (t == 2) check(ack_prev, "R8", "cap abort one cycle after ack", ack_prev, 1);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'hDEAD_0000 + 32'(i);
    repeat (3) @(negedge clk);
    check({busy, rd_req, xfer_req, done, err} == 5'b0, "R10", "outputs in reset",
          {busy, rd_req, xfer_req, done, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy, rd_req, xfer_req, done, err} == 5'b0, "R10", "outputs after reset",
          {busy, rd_req, xfer_req, done, err}, 0);

    // single final descriptor, write direction
    put_entry(32'h100, 32'h1234_5678, 32'd5, 8'hA0, 4'h3, 32'h0000_0F00);
    run_walk(32'h100, 0, 0);

    // three descriptors, misaligned start and next pointers, slow memory
    rd_lat = 2; ack_lat = 3;
    put_entry(32'h200, 32'hA000_0000, 32'd1, 8'h10, 4'h6, 32'h0000_02C3);
    put_entry(32'h2C0, 32'hB000_0010, 32'h0010_0000, 8'h30, 4'h0, 32'h0000_0344);
    put_entry(32'h340, 32'hC000_0020, 32'd7, 8'h80, 4'hC, 32'h0000_03F8);
    run_walk(32'h205, 0, 0);

    // zero length in the second descriptor
    rd_lat = 0; ack_lat = 0;
    put_entry(32'h400, 32'h0000_4000, 32'd2, 8'h00, 4'h1, 32'h0000_0420);
    put_entry(32'h420, 32'h0000_5000, 32'd0, 8'h80, 4'h1, 32'h0);
    run_walk(32'h400, 1, 0);

    // chain that runs past the cap
    ack_lat = 1;
    for (int i = 0; i < MAXE; i++)
      put_entry(32'h500 + 32'(i*32), 32'h5000_0000 + 32'(i), 32'(i + 1), 8'h00, 4'(i),
                32'h500 + 32'((i + 1) * 32));
    mem[32'h600 >> 2] = 32'h9;
    run_walk(32'h500, 2, 0);

    // chain of exactly the cap, ending final
    for (int i = 0; i < MAXE; i++)
      put_entry(32'h800 + 32'(i*32), 32'h8000_0000 + 32'(i), 32'd3,
                (i == MAXE - 1) ? 8'h80 : 8'h20, 4'h2, 32'h800 + 32'((i + 1) * 32));
    run_walk(32'h800, 0, 0);

    // a second start during the walk must not disturb it
    ack_lat = 8; rd_lat = 1;
    put_entry(32'h100, 32'h2222_0000, 32'd9, 8'h90, 4'h7, 32'h0000_0400);
    run_walk(32'h100, 0, 3);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule